// File: doc/BRIEF.md
# Idle-State Wake Qualifier

This block watches the wake sources of a processor that has entered a low-power idle state. The states are C2, C3 and C4. The block decides whether a source should end the idle period. If it should, the block emits a one-cycle break pulse that requests a return to C0. One case does not end the idle period: bus-master traffic while a configuration bit asks for it to be handled by a demotion. In that case the block emits a one-cycle request to fall back to C2.

All sources are level inputs sampled on the clock. The idle state is an input with the encoding 0 = C0, 1 = C2, 2 = C3, 3 = C4. The block issues at most one break pulse per idle residency and re-arms when the state returns to C0. A message from the memory controller can also break the idle period. It counts only inside a window that opens with the C2 acknowledge and closes with the C0 acknowledge.

Top module: `idle_wake_qual`

## Requirements
- R1: After reset, `wake_brk` and `fall_c2` are 0.
- R2: An IRQ line that is active while its mask bit is 0 causes a break. A mask bit of 1 hides that line.
- R3: With `apic_en` = 0, only IRQ lines 0 to 15 count. With `apic_en` = 1, all 24 lines count.
- R4: An active `sci_req`, `nmi_req`, `smi_req` or `init_req` causes a break from any idle state.
- R5: Bus-master activity causes a break only in C3 or C4, only with `bm_reload` = 1 and only with `bm_to_c2` = 0. Bus-master activity is any `bm_req` line or `bm_busy`.
- R6: With `bm_to_c2` = 1, bus-master activity in C3 or C4 gives no break. It gives one `fall_c2` pulse per stay in C3/C4.
- R7: `fpe_pin` causes a break only while `fpe_en` = 1 and the state is C2.
- R8: `mc_wake` causes a break only while the window is open. The window opens in the cycle after `c2_ack` is seen. It closes when `c0_ack` is seen, including in the same cycle as `c0_ack`.
- R9: In C0, no source produces a pulse on either output.
- R10: At most one `wake_brk` pulse is issued per idle residency. The block re-arms once the state has been C0 for one cycle.
- R11: If a break and a C2 demotion are both due in the same cycle, only `wake_brk` is issued.
- R12: A pulse appears in the cycle after the clock edge that samples its cause, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cstate | input | 2 | Current idle state: 0 C0, 1 C2, 2 C3, 3 C4 |
| irq_req | input | 24 | Interrupt request lines |
| irq_mask | input | 24 | Per-line mask, 1 = masked |
| apic_en | input | 1 | 1 = 24-line mode, 0 = 16-line mode |
| sci_req | input | 1 | System control interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt event |
| smi_req | input | 1 | System management interrupt event |
| init_req | input | 1 | Processor init event |
| bm_req | input | 4 | Bus-master request lines |
| bm_busy | input | 1 | External bus-master busy indication |
| bm_reload | input | 1 | Config: bus-master activity may break deep states |
| bm_to_c2 | input | 1 | Config: bus-master activity demotes to C2 instead |
| fpe_pin | input | 1 | Floating-point error pin |
| fpe_en | input | 1 | Config: use the error pin as a break indication |
| mc_wake | input | 1 | Memory-controller request to return to C0 |
| c2_ack | input | 1 | C2 acknowledge seen |
| c0_ack | input | 1 | C0 acknowledge seen |
| wake_brk | output | 1 | One-cycle break pulse |
| fall_c2 | output | 1 | One-cycle request to return to C2 |

## Verification
The assertions assume that the state is held steady while the block is waiting, and that it passes through C0 before a new idle residency starts. Without that, the one-pulse-per-residency rule has no meaning. They also assume that the acknowledge inputs are sampled levels valid at each edge. The stimulus changes inputs only at the falling edge. Every residency ends with a C0 cycle, and each source is raised alone except where priority or window timing is being tested.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  typedef enum logic [1:0] {
    ST_C0 = 2'd0,
    ST_C2 = 2'd1,
    ST_C3 = 2'd2,
    ST_C4 = 2'd3
  } idle_st_e;

  function automatic logic st_idle(input logic [1:0] s);
    return s != ST_C0;
  endfunction

  function automatic logic st_deep(input logic [1:0] s);
    return (s == ST_C3) || (s == ST_C4);
  endfunction

  function automatic logic st_shallow(input logic [1:0] s);
    return s == ST_C2;
  endfunction

endpackage

// File: rtl/iwq_irq_qual.sv
module iwq_irq_qual #(
  parameter int N_IRQ   = 24,
  parameter int N_LEGACY = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             apic_en,
  input  logic             sci_req,
  output logic             int_wake
);

  logic [N_IRQ-1:0] line_ok;
  logic [N_IRQ-1:0] line_live;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    if (i < N_LEGACY) begin : g_legacy
      assign line_ok[i] = 1'b1;
    end else begin : g_apic_only
      assign line_ok[i] = apic_en;
    end
    assign line_live[i] = irq_req[i] & ~irq_mask[i] & line_ok[i];
  end

  assign int_wake = (|line_live) | sci_req;

  // R2: with every request masked or idle and no SCI there is no interrupt wake
  p_mask_hides_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((irq_req & ~irq_mask) == '0) && !sci_req) |-> !int_wake);

endmodule

// File: rtl/iwq_msg_window.sv
module iwq_msg_window (
  input  logic clk,
  input  logic rst_n,
  input  logic c2_ack,
  input  logic c0_ack,
  input  logic mc_wake,
  output logic msg_wake
);

  logic win_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      win_q <= 1'b0;
    else if (c0_ack) win_q <= 1'b0;
    else if (c2_ack) win_q <= 1'b1;
  end

  assign msg_wake = mc_wake & win_q & ~c0_ack;

  // R8: a C0 acknowledge always closes the window
  p_win_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c0_ack |=> !win_q);

  // R8: the window never opens without a prior C2 acknowledge
  p_win_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> $past(c2_ack));

endmodule

// File: rtl/iwq_pulse_arb.sv
module iwq_pulse_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic in_c0,
  input  logic in_deep,
  input  logic brk_lvl,
  input  logic dem_lvl,
  output logic brk_pulse,
  output logic dem_pulse
);

  logic brk_seen, dem_seen;
  logic fire_brk, fire_dem;

  assign fire_brk = brk_lvl & ~brk_seen;
  assign fire_dem = dem_lvl & ~brk_lvl & ~dem_seen & ~brk_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pulse <= 1'b0;
      dem_pulse <= 1'b0;
      brk_seen  <= 1'b0;
      dem_seen  <= 1'b0;
    end else begin
      brk_pulse <= fire_brk;
      dem_pulse <= fire_dem;
      brk_seen  <= in_c0 ? 1'b0 : (brk_seen | fire_brk);
      dem_seen  <= in_deep ? (dem_seen | fire_dem) : 1'b0;
    end
  end

  // R10: a break pulse is never followed directly by another
  p_single_brk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);

  // R11: the two outputs never pulse together
  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_pulse && dem_pulse));

  // R11: a demotion is never granted in a cycle where a break was due
  p_brk_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dem_pulse |-> !$past(brk_lvl));

endmodule

// File: rtl/idle_wake_qual.sv
module idle_wake_qual
  import idle_wake_pkg::*;
#(
  parameter int N_IRQ    = 24,
  parameter int N_LEGACY = 16,
  parameter int N_BM     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cstate,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             apic_en,
  input  logic             sci_req,
  input  logic             nmi_req,
  input  logic             smi_req,
  input  logic             init_req,
  input  logic [N_BM-1:0]  bm_req,
  input  logic             bm_busy,
  input  logic             bm_reload,
  input  logic             bm_to_c2,
  input  logic             fpe_pin,
  input  logic             fpe_en,
  input  logic             mc_wake,
  input  logic             c2_ack,
  input  logic             c0_ack,
  output logic             wake_brk,
  output logic             fall_c2
);

  logic idle_now, deep_now, c2_now;
  logic int_wake, evt_wake, bm_any, bm_wake, fpe_wake, msg_wake;
  logic brk_lvl, dem_lvl;

  assign idle_now = st_idle(cstate);
  assign deep_now = st_deep(cstate);
  assign c2_now   = st_shallow(cstate);

  iwq_irq_qual #(.N_IRQ(N_IRQ), .N_LEGACY(N_LEGACY)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_mask (irq_mask),
    .apic_en  (apic_en),
    .sci_req  (sci_req),
    .int_wake (int_wake)
  );

  iwq_msg_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .c2_ack   (c2_ack),
    .c0_ack   (c0_ack),
    .mc_wake  (mc_wake),
    .msg_wake (msg_wake)
  );

  assign evt_wake = nmi_req | smi_req | init_req;
  assign bm_any   = (|bm_req) | bm_busy;
  assign bm_wake  = bm_any & bm_reload & ~bm_to_c2 & deep_now;
  assign fpe_wake = fpe_pin & fpe_en & c2_now;

  assign brk_lvl = idle_now & (int_wake | evt_wake | bm_wake | fpe_wake | msg_wake);
  assign dem_lvl = bm_any & bm_to_c2 & deep_now;

  iwq_pulse_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_c0     (!idle_now),
    .in_deep   (deep_now),
    .brk_lvl   (brk_lvl),
    .dem_lvl   (dem_lvl),
    .brk_pulse (wake_brk),
    .dem_pulse (fall_c2)
  );

  // R9: no break pulse follows a cycle spent in C0
  p_quiet_c0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_brk |-> $past(cstate) != ST_C0);

  // R6: a demotion only follows bus-master traffic in a deep state with demotion enabled
  p_dem_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_c2 |-> $past(bm_to_c2 && deep_now && bm_any));

  // R12: a demotion pulse lasts one cycle
  p_dem_width_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fall_c2 |=> !fall_c2);

endmodule

// File: tb/sim_idle_wake_qual.sv
`timescale 1ns/100ps
module sim_idle_wake_qual;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cstate = 2'd0;
  logic [23:0] irq_req = '0, irq_mask = '0;
  logic apic_en = 1'b1;
  logic sci_req = 0, nmi_req = 0, smi_req = 0, init_req = 0;
  logic [3:0] bm_req = '0;
  logic bm_busy = 0, bm_reload = 0, bm_to_c2 = 0;
  logic fpe_pin = 0, fpe_en = 0, mc_wake = 0, c2_ack = 0, c0_ack = 0;
  logic wake_brk, fall_c2;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic  brk;
    logic  dem;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  idle_wake_qual u0 (
    .clk(clk), .rst_n(rst_n), .cstate(cstate), .irq_req(irq_req), .irq_mask(irq_mask),
    .apic_en(apic_en), .sci_req(sci_req), .nmi_req(nmi_req), .smi_req(smi_req),
    .init_req(init_req), .bm_req(bm_req), .bm_busy(bm_busy), .bm_reload(bm_reload),
    .bm_to_c2(bm_to_c2), .fpe_pin(fpe_pin), .fpe_en(fpe_en), .mc_wake(mc_wake),
    .c2_ack(c2_ack), .c0_ack(c0_ack), .wake_brk(wake_brk), .fall_c2(fall_c2)
  );

  // monitor: compare just after each edge against the expected item for that edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (wake_brk !== e.brk || fall_c2 !== e.dem) begin
        fails++;
        $display("FAIL %s: brk/dem actual %b%b expected %b%b", e.tag, wake_brk, fall_c2, e.brk, e.dem);
      end
    end
  end

  // driver: inputs already set for this cycle; queue what the next edge must yield
  task automatic tick(input logic eb, input logic ed, input string tag);
    exp_t e;
    e.brk = eb; e.dem = ed; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic quiet();
    irq_req = '0; sci_req = 0; nmi_req = 0; smi_req = 0; init_req = 0;
    bm_req = '0; bm_busy = 0; fpe_pin = 0; mc_wake = 0; c2_ack = 0; c0_ack = 0;
    cstate = 2'd0;
    tick(1'b0, 1'b0, "R10 rearm in C0");
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wake_brk !== 1'b0 || fall_c2 !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %b%b expected 00", wake_brk, fall_c2);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9: sources in C0 are ignored
    cstate = 2'd0; irq_req[3] = 1; nmi_req = 1;
    tick(0, 0, "R9 irq+nmi in C0");
    quiet();

    // R2 R12 R10
    cstate = 2'd1; irq_req[3] = 1;
    tick(1, 0, "R2 R12 unmasked irq in C2");
    tick(0, 0, "R10 held source no second pulse");
    quiet();

    cstate = 2'd2; irq_req[3] = 1; irq_mask[3] = 1;
    tick(0, 0, "R2 masked irq");
    irq_mask[3] = 0;
    tick(1, 0, "R2 unmasked irq in C3");
    quiet();

    // R3
    apic_en = 0; cstate = 2'd1; irq_req[20] = 1;
    tick(0, 0, "R3 line 20 in 16-line mode");
    apic_en = 1;
    tick(1, 0, "R3 line 20 in 24-line mode");
    quiet();

    // R4
    cstate = 2'd3; sci_req = 1;  tick(1, 0, "R4 sci");  quiet();
    cstate = 2'd3; nmi_req = 1;  tick(1, 0, "R4 nmi");  quiet();
    cstate = 2'd3; smi_req = 1;  tick(1, 0, "R4 smi");  quiet();
    cstate = 2'd3; init_req = 1; tick(1, 0, "R4 init"); quiet();

    // R5
    bm_reload = 1; cstate = 2'd1; bm_req[1] = 1;
    tick(0, 0, "R5 bus master in C2");
    bm_reload = 0; cstate = 2'd2;
    tick(0, 0, "R5 bus master reload off");
    bm_reload = 1;
    tick(1, 0, "R5 bus master reload on C3");
    quiet();
    cstate = 2'd3; bm_busy = 1;
    tick(1, 0, "R5 busy input C4");
    quiet();

    // R6
    bm_to_c2 = 1; cstate = 2'd2; bm_req[0] = 1;
    tick(0, 1, "R6 demote in C3");
    tick(0, 0, "R6 single demote");
    cstate = 2'd1;
    tick(0, 0, "R6 no action in C2");
    quiet();

    // R11
    cstate = 2'd3; bm_req[2] = 1; nmi_req = 1;
    tick(1, 0, "R11 break beats demote");
    quiet();
    bm_to_c2 = 0;

    // R7
    cstate = 2'd1; fpe_pin = 1; fpe_en = 0;
    tick(0, 0, "R7 fpe disabled");
    fpe_en = 1;
    tick(1, 0, "R7 fpe enabled C2");
    quiet();
    cstate = 2'd2; fpe_pin = 1;
    tick(0, 0, "R7 fpe in C3");
    quiet();
    fpe_en = 0;

    // R8
    cstate = 2'd1; mc_wake = 1;
    tick(0, 0, "R8 msg window closed");
    c2_ack = 1;
    tick(0, 0, "R8 msg with c2 ack same cycle");
    c2_ack = 0;
    tick(1, 0, "R8 msg in window");
    cstate = 2'd0; mc_wake = 0; c0_ack = 1;
    tick(0, 0, "R8 c0 ack");
    c0_ack = 0; cstate = 2'd1; mc_wake = 1;
    tick(0, 0, "R8 msg after close");
    mc_wake = 0; c2_ack = 1;
    tick(0, 0, "R8 reopen");
    c2_ack = 0; mc_wake = 1; c0_ack = 1;
    tick(0, 0, "R8 msg with c0 ack same cycle");
    quiet();
    c2_ack = 1; tick(0, 0, "R8 open in C0");
    c2_ack = 0; mc_wake = 1;
    tick(0, 0, "R9 msg in C0 with open window");
    quiet();

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule